// File: doc/BRIEF.md
# Dual-Comparator Programmable Timer Channel

This block is a single timer channel. A 16-bit up-counter advances on a divided tick taken from one of two tick sources, a slow one and a fast one. Both sources are single-cycle enables in the system clock domain. Two compare registers watch the counter. The second compare register sets the period of the count. The first sets the point where the output level changes. Each comparator has a two-bit mode, and it raises a sticky event flag when the counter reaches its value.

Software reaches the channel through a window of four 16-bit registers at even byte offsets. The first write to the setup register after reset fixes the configuration and sets a lock bit. After that, only the run bit can change, and the two flags can only be cleared. Reads return the stored values with no wait state.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both compare registers read 0xFFFF, the counter reads 0, the setup register reads 0 and the output is low.
- R2: The byte offsets are 0 for compare A, 2 for compare B, 4 for the counter and 6 for setup. Reads are combinational. An odd offset reads 0 and a write to it is dropped. A write to the counter loads it, and the load wins over a tick in the same cycle.
- R3: Setup bits from 15 down to 0 hold: run, flag B, flag A, lock, stop enable, external enable, mode B (2 bits), mode A (2 bits), reverse enable, source select and prescale (4 bits). The first setup write after reset loads every configuration field and sets the lock bit. The lock bit stays set until reset.
- R4: Once the lock bit is set, a setup write changes only the run bit and the clear-on-one flag bits. Every other field keeps its value.
- R5: Writing 1 to bit 13 clears flag A, and writing 1 to bit 14 clears flag B. Writing 0 to either bit leaves that flag unchanged.
- R6: Source select 0 takes the slow tick and 1 takes the fast tick. The other source has no effect. A prescale value p passes one tick in every 2^p ticks of the selected source.
- R7: While run is 1 the counter advances on each divided tick. While run is 0 the counter holds its value and the prescaler phase returns to zero. Writing 0 to setup stops the channel.
- R8: A tick that finds the counter equal to compare B returns it to 0, so one period is compare B + 1 divided ticks.
- R9: When a tick moves the counter onto a comparator's value and that comparator's mode is not 0, the comparator's flag is set. A comparator in mode 0 never sets its flag.
- R10: A write of 0 to compare B is ignored. While mode A is not 0, a write to compare A above compare B is ignored, and a write to compare B below compare A is ignored.
- R11: The mode encoding is 0 off, 1 equal, 2 at-or-above and 3 latch. The output is low in mode 0. In mode 1 it is high while the counter equals compare A. In mode 2 it is high while the counter is at or above compare A. In mode 3 it goes high when a tick moves the counter onto compare A and goes low when the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | Slow time-base enable pulse |
| fast_tick_i | input | 1 | Fast time-base enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte offset inside the channel window |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i |
| out_o | output | 1 | Comparator-driven output level |

## Verification
The bench attacks the lock. A second setup write tries to change every field, and a design that reloaded the fields would show the new prescale and modes when setup is read back. The bench also probes the edges of the count. The flags must appear on the exact tick that lands on each compare value, and the counter must wrap after compare B and not at the top of its range. A mode-0 comparator must never flag. The compare-write guards and the clear-on-one bits are checked in both directions, so a design that cleared on 0 or accepted a zero period is caught. The three output modes run over the same counter values, so equal, at-or-above and latch each give a different output on a different tick. A prescaler that divided by p instead of 2^p, or that listened to the unselected source, would move the tick on which the counter reaches 1.

// File: rtl/dct_pkg.sv
package dct_pkg;

    // Comparator mode field encoding.
    typedef enum logic [1:0] {
        CMP_OFF = 2'd0,
        CMP_EQ  = 2'd1,
        CMP_GE  = 2'd2,
        CMP_LAT = 2'd3
    } cmp_mode_e;

    // Word index (byte offset bits 2:1) of each register.
    localparam logic [1:0] WIDX_CMPA = 2'd0;
    localparam logic [1:0] WIDX_CMPB = 2'd1;
    localparam logic [1:0] WIDX_CNT  = 2'd2;
    localparam logic [1:0] WIDX_CFG  = 2'd3;

    // Setup register bit positions.
    localparam int unsigned B_RUN   = 15;
    localparam int unsigned B_FLGB  = 14;
    localparam int unsigned B_FLGA  = 13;
    localparam int unsigned B_LOCK  = 12;
    localparam int unsigned B_STOP  = 11;
    localparam int unsigned B_EXT   = 10;
    localparam int unsigned B_MODEB = 8;
    localparam int unsigned B_MODEA = 6;
    localparam int unsigned B_REV   = 5;
    localparam int unsigned B_SRC   = 4;

    localparam int unsigned SCALE_BITS = 4;

    typedef struct packed {
        logic                  run;
        logic                  stop_en;
        logic                  ext_en;
        cmp_mode_e             mode_b;
        cmp_mode_e             mode_a;
        logic                  rev_en;
        logic                  src_fast;
        logic [SCALE_BITS-1:0] scale;
    } cfg_t;

endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
    parameter int unsigned SCALE_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               src_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);

    localparam int unsigned DIV_W = (1 << SCALE_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = ~({DIV_W{1'b1}} << scale_i);
        st_d   = st_q;
        tick_o = 1'b0;
        if (!run_i) begin
            st_d.phase = '0;
        end else if (src_i) begin
            if (st_q.phase == limit) begin
                tick_o     = 1'b1;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dct_counter.sv
module dct_counter
    import dct_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                ld_i,
    input  logic [W-1:0]        ld_val_i,
    input  logic [1:0][W-1:0]   cmp_i,
    input  logic [1:0]          cmp_en_i,
    input  cmp_mode_e           out_mode_i,
    output logic [W-1:0]        cnt_o,
    output logic [1:0]          hit_o,
    output logic                out_o
);

    localparam int unsigned NCMP = 2;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         lat;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic         adv;
    logic         wrap;
    logic [W-1:0] nxt;

    assign adv  = tick_i & ~ld_i;
    assign wrap = (st_q.cnt == cmp_i[1]);
    assign nxt  = wrap ? '0 : st_q.cnt + 1'b1;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign hit_o[g] = adv & cmp_en_i[g] & (nxt == cmp_i[g]);
    end

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (adv) begin
            st_d.cnt = nxt;
            if (nxt == cmp_i[0]) begin
                st_d.lat = 1'b1;
            end else if (wrap) begin
                st_d.lat = 1'b0;
            end
        end
    end

    always_comb begin
        unique case (out_mode_i)
            CMP_EQ:  out_o = (st_q.cnt == cmp_i[0]);
            CMP_GE:  out_o = (st_q.cnt >= cmp_i[0]);
            CMP_LAT: out_o = st_q.lat;
            default: out_o = 1'b0;
        endcase
    end

    assign cnt_o = st_q.cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic [2:0]   addr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [1:0]   hit_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] rd_data_o,
    output logic [W-1:0] cmpa_o,
    output logic [W-1:0] cmpb_o,
    output cfg_t         cfg_o,
    output logic         lock_o,
    output logic [1:0]   flag_o,
    output logic         ld_o
);

    typedef struct packed {
        logic [W-1:0] cmpa;
        logic [W-1:0] cmpb;
        cfg_t         cfg;
        logic         lock;
        logic         flga;
        logic         flgb;
    } reg_st_t;

    reg_st_t    st_d, st_q;
    logic       even;
    logic [1:0] widx;
    logic       ena;
    logic       wr_cfg;

    assign even   = ~addr_i[0];
    assign widx   = addr_i[2:1];
    assign ena    = (st_q.cfg.mode_a != CMP_OFF);
    assign wr_cfg = wr_en_i & even & (widx == WIDX_CFG);
    assign ld_o   = wr_en_i & even & (widx == WIDX_CNT);

    always_comb begin
        st_d = st_q;
        if (wr_en_i && even) begin
            unique case (widx)
                WIDX_CMPA: begin
                    if (!ena || (wr_data_i <= st_q.cmpb)) begin
                        st_d.cmpa = wr_data_i;
                    end
                end
                WIDX_CMPB: begin
                    if ((wr_data_i != '0) && (!ena || (wr_data_i >= st_q.cmpa))) begin
                        st_d.cmpb = wr_data_i;
                    end
                end
                default: ;
            endcase
        end
        if (wr_cfg) begin
            if (!st_q.lock) begin
                st_d.cfg.stop_en  = wr_data_i[B_STOP];
                st_d.cfg.ext_en   = wr_data_i[B_EXT];
                st_d.cfg.mode_b   = cmp_mode_e'(wr_data_i[B_MODEB +: 2]);
                st_d.cfg.mode_a   = cmp_mode_e'(wr_data_i[B_MODEA +: 2]);
                st_d.cfg.rev_en   = wr_data_i[B_REV];
                st_d.cfg.src_fast = wr_data_i[B_SRC];
                st_d.cfg.scale    = wr_data_i[SCALE_BITS-1:0];
                st_d.lock         = 1'b1;
            end
            st_d.cfg.run = wr_data_i[B_RUN];
            if (wr_data_i[B_FLGA]) begin
                st_d.flga = 1'b0;
            end
            if (wr_data_i[B_FLGB]) begin
                st_d.flgb = 1'b0;
            end
        end
        // A new event in the same cycle outranks a clear.
        if (hit_i[0]) begin
            st_d.flga = 1'b1;
        end
        if (hit_i[1]) begin
            st_d.flgb = 1'b1;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (even) begin
            unique case (widx)
                WIDX_CMPA: rd_data_o = st_q.cmpa;
                WIDX_CMPB: rd_data_o = st_q.cmpb;
                WIDX_CNT:  rd_data_o = cnt_i;
                default:   rd_data_o = {st_q.cfg.run, st_q.flgb, st_q.flga, st_q.lock,
                                        st_q.cfg.stop_en, st_q.cfg.ext_en,
                                        st_q.cfg.mode_b, st_q.cfg.mode_a,
                                        st_q.cfg.rev_en, st_q.cfg.src_fast,
                                        st_q.cfg.scale};
            endcase
        end
    end

    assign cmpa_o = st_q.cmpa;
    assign cmpb_o = st_q.cmpb;
    assign cfg_o  = st_q.cfg;
    assign lock_o = st_q.lock;
    assign flag_o = {st_q.flgb, st_q.flga};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.cmpa <= '1;
            st_q.cmpb <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              slow_tick_i,
    input  logic              fast_tick_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              out_o
);

    cfg_t              cfg_w;
    logic              lock_w;
    logic [1:0]        flag_w;
    logic [1:0]        hit_w;
    logic              ld_w;
    logic              tick_w;
    logic              src_w;
    logic [DATA_W-1:0] cnt_w;
    logic [DATA_W-1:0] cmpa_w;
    logic [DATA_W-1:0] cmpb_w;

    dct_regs #(.W(DATA_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .hit_i     (hit_w),
        .cnt_i     (cnt_w),
        .rd_data_o (rd_data_o),
        .cmpa_o    (cmpa_w),
        .cmpb_o    (cmpb_w),
        .cfg_o     (cfg_w),
        .lock_o    (lock_w),
        .flag_o    (flag_w),
        .ld_o      (ld_w)
    );

    assign src_w = cfg_w.src_fast ? fast_tick_i : slow_tick_i;

    dct_prescale #(.SCALE_W(SCALE_BITS)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (cfg_w.run),
        .src_i   (src_w),
        .scale_i (cfg_w.scale),
        .tick_o  (tick_w)
    );

    dct_counter #(.W(DATA_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_w),
        .ld_i       (ld_w),
        .ld_val_i   (wr_data_i),
        .cmp_i      ({cmpb_w, cmpa_w}),
        .cmp_en_i   ({cfg_w.mode_b != CMP_OFF, cfg_w.mode_a != CMP_OFF}),
        .out_mode_i (cfg_w.mode_a),
        .cnt_o      (cnt_w),
        .hit_o      (hit_w),
        .out_o      (out_o)
    );

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         wr_en_i,
    input logic [2:0]   addr_i,
    input logic [W-1:0] wr_data_i,
    input logic         lock,
    input logic [1:0]   flag,
    input logic         run,
    input logic         tick,
    input logic         ld,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmpb,
    input logic [1:0]   mode_a,
    input logic         out
);

    logic clr_a;
    assign clr_a = wr_en_i && (addr_i == 3'd6) && wr_data_i[13];

    // R3: the lock bit never falls without reset
    assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock |=> lock);

    // R8: a tick at compare B returns the counter to zero
    assert_wrap_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !ld && (cnt == cmpb)) |=> (cnt == '0));

    // R5: flag A only falls on a clear-on-one write
    assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag[0] && !clr_a) |=> flag[0]);

    // R10: compare B never holds zero
    assert_cmpb_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmpb != '0);

    // R11: mode 0 keeps the output low
    assert_out_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_a == 2'd0) |-> !out);

    // R7: a stopped channel holds its count
    assert_hold_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !ld) |=> $stable(cnt));

endmodule

bind dual_cmp_timer dct_checker #(.W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .lock      (lock_w),
    .flag      (flag_w),
    .run       (cfg_w.run),
    .tick      (tick_w),
    .ld        (ld_w),
    .cnt       (cnt_w),
    .cmpb      (cmpb_w),
    .mode_a    (cfg_w.mode_a),
    .out       (out_o)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;

    localparam int PERIOD = 20;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        slow_tick_i = 1'b0;
    logic        fast_tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [15:0] wr_data_i = 16'h0;
    logic [15:0] rd_data_o;
    logic        out_o;

    localparam logic [2:0] A_CMPA = 3'd0, A_CMPB = 3'd2, A_CNT = 3'd4, A_CFG = 3'd6;

    dual_cmp_timer dut (.*);

    always #(PERIOD/2) clk_i = ~clk_i;

    typedef struct {
        bit          pin;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Monitor: pops each expected item and compares it with the live output.
    initial begin
        forever begin
            wait (q.size() != 0);
            #1;
            begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                act = it.pin ? {15'h0, out_o} : rd_data_o;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk_i);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            if (fast) fast_tick_i = 1'b1; else slow_tick_i = 1'b1;
            @(negedge clk_i);
            fast_tick_i = 1'b0; slow_tick_i = 1'b0;
        end
    endtask

    task automatic exp_reg(input logic [2:0] a, input logic [15:0] e, input string tag);
        item_t it;
        addr_i = a;
        it.pin = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk_i);
    endtask

    task automatic exp_pin(input logic e, input string tag);
        item_t it;
        it.pin = 1'b1; it.exp = {15'h0, e}; it.tag = tag;
        q.push_back(it);
        @(negedge clk_i);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic finish_run();
        wait (q.size() == 0);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset values
        exp_reg(A_CMPA, 16'hFFFF, "R1 cmpA reset");
        exp_reg(A_CMPB, 16'hFFFF, "R1 cmpB reset");
        exp_reg(A_CNT,  16'h0000, "R1 counter reset");
        exp_reg(A_CFG,  16'h0000, "R1 setup reset");
        exp_pin(1'b0, "R1 output reset");

        // Pass 1: mode B latch, mode A at-or-above, reverse, fast source, p=0, stopped
        wr(A_CFG, 16'h03B0);
        exp_reg(A_CFG, 16'h13B0, "R3 first setup write and lock");
        wr(A_CMPB, 16'h0000);
        exp_reg(A_CMPB, 16'hFFFF, "R10 zero compare B ignored");
        wr(A_CMPA, 16'h0003);
        exp_reg(A_CMPA, 16'h0003, "R2 compare A offset");
        wr(A_CMPB, 16'h0005);
        exp_reg(A_CMPB, 16'h0005, "R2 compare B offset");
        wr(A_CMPA, 16'h0009);
        exp_reg(A_CMPA, 16'h0003, "R10 compare A above B ignored");
        wr(A_CMPB, 16'h0002);
        exp_reg(A_CMPB, 16'h0005, "R10 compare B below A ignored");
        exp_reg(3'd1, 16'h0000, "R2 odd offset reads zero");
        wr(A_CFG, 16'h800F);
        exp_reg(A_CFG, 16'h93B0, "R4 locked write changes run only");
        pulse(1'b0, 2);
        exp_reg(A_CNT, 16'h0000, "R6 unselected slow source ignored");
        pulse(1'b1, 2);
        exp_reg(A_CNT, 16'h0002, "R7 counts when running");
        exp_pin(1'b0, "R11 at-or-above low below A");
        pulse(1'b1, 1);
        exp_reg(A_CNT, 16'h0003, "R7 count three");
        exp_pin(1'b1, "R11 at-or-above high at A");
        exp_reg(A_CFG, 16'hB3B0, "R9 flag A on reaching A");
        pulse(1'b1, 2);
        exp_reg(A_CFG, 16'hF3B0, "R9 flag B on reaching B");
        exp_pin(1'b1, "R11 at-or-above high above A");
        pulse(1'b1, 1);
        exp_reg(A_CNT, 16'h0000, "R8 wrap after compare B");
        exp_pin(1'b0, "R11 at-or-above low after wrap");
        wr(A_CFG, 16'hA000);
        exp_reg(A_CFG, 16'hD3B0, "R5 clear A only, B kept on zero bit");
        wr(A_CFG, 16'hC000);
        exp_reg(A_CFG, 16'h93B0, "R5 clear B");
        pulse(1'b1, 1);
        exp_reg(A_CNT, 16'h0001, "R7 count after clear");
        wr(A_CFG, 16'h0000);
        exp_reg(A_CFG, 16'h13B0, "R7 zero write stops");
        pulse(1'b1, 3);
        exp_reg(A_CNT, 16'h0001, "R7 stopped counter holds");
        wr(A_CNT, 16'h0004);
        exp_reg(A_CNT, 16'h0004, "R2 counter load");

        // Pass 2: mode A equal, mode B off, slow source, p=2, running
        do_reset();
        wr(A_CMPA, 16'h0002);
        wr(A_CMPB, 16'h0003);
        wr(A_CFG, 16'h8042);
        exp_reg(A_CFG, 16'h9042, "R3 second configuration");
        pulse(1'b0, 3);
        exp_reg(A_CNT, 16'h0000, "R6 prescale holds for three source ticks");
        pulse(1'b1, 2);
        exp_reg(A_CNT, 16'h0000, "R6 unselected fast source ignored");
        pulse(1'b0, 1);
        exp_reg(A_CNT, 16'h0001, "R6 fourth source tick advances");
        pulse(1'b0, 4);
        exp_reg(A_CNT, 16'h0002, "R6 divide by four");
        exp_pin(1'b1, "R11 equal high on match");
        exp_reg(A_CFG, 16'hB042, "R9 flag A in equal mode");
        pulse(1'b0, 4);
        exp_pin(1'b0, "R11 equal low after match");
        exp_reg(A_CFG, 16'hB042, "R9 mode-0 comparator B never flags");
        pulse(1'b0, 4);
        exp_reg(A_CNT, 16'h0000, "R8 wrap at compare B prescaled");

        // Pass 3: mode A latch, mode B equal, fast source, p=0, running
        do_reset();
        wr(A_CMPA, 16'h0001);
        wr(A_CMPB, 16'h0003);
        wr(A_CFG, 16'h81D0);
        exp_reg(A_CFG, 16'h91D0, "R3 third configuration");
        pulse(1'b1, 1);
        exp_pin(1'b1, "R11 latch sets at A");
        pulse(1'b1, 1);
        exp_pin(1'b1, "R11 latch holds past A");
        pulse(1'b1, 1);
        exp_pin(1'b1, "R11 latch holds at B");
        exp_reg(A_CFG, 16'hF1D0, "R9 both flags set");
        pulse(1'b1, 1);
        exp_reg(A_CNT, 16'h0000, "R8 wrap to zero");
        exp_pin(1'b0, "R11 latch clears on wrap");

        done = 1'b1;
        finish_run();
    end

endmodule